// File: doc/BRIEF.md
# Delta Sample Playback Channel

This block plays 1-bit delta-coded audio samples. It reads sample bytes from CPU memory through a DMA request/acknowledge handshake, and the system stalls the CPU while each fetch is served. A programmable timer clocks out one bit at a time. Each 1 bit raises a 7-bit output level by two steps and each 0 bit lowers it by two.

When a sample that does not loop runs out of bytes, the channel can raise an interrupt. The interrupt stays asserted until software writes the status register or disables it. Software can therefore use the channel as a periodic timer: it picks the rate and the length, waits for the interrupt, acknowledges it and starts the channel again. The interrupt output is an open-drain pull-down enable. A high value means the channel pulls the shared, externally pulled-up interrupt line low.

Top module: `dsd_channel`

## Requirements
- R1: After synchronous reset: level is 0, `irq_pull_low` is 0, `active` is 0 and `dma_req` is 0.
- R2: Control bits 3:0 select the timer period in clock cycles from a 16-entry table. Index 0 gives 428 cycles and index 15 gives 54. While bytes keep arriving, the level changes once per period.
- R3: Fetches start at 0xC000 + A*64, where A is the start-code register (select 2). Each fetch advances the address by one, and the address wraps from 0xFFFF to 0x8000.
- R4: One playback fetches L*16+1 bytes, where L is the length-code register (select 3). `active` stays high while fetched bytes remain and drops when none remain.
- R5: Bits are used LSB first. A 1 bit adds 2 to the level and a 0 bit subtracts 2. A step that would leave the range 0..127 leaves the level unchanged.
- R6: A write to select 1 loads wdata bits 6:0 into the level, visible one cycle later. Bit 7 is ignored.
- R7: When control bit 7 (IRQ enable) is 1 and bit 6 (loop) is 0, fetching the last byte sets `irq_pull_low`. It stays set until it is acknowledged. With IRQ enable at 0, it is never set.
- R8: Any write to the status register (select 4) clears `irq_pull_low`.
- R9: A status write with bit 4 = 1 restarts playback when no bytes remain. A status write with bit 4 = 0 sets the remaining count to 0, which stops further fetches.
- R10: A control write with bit 7 = 0 clears a pending interrupt.
- R11: With the loop bit set, the last fetch reloads the start address and the length, and no interrupt is raised.
- R12: `dma_req` stays high with a stable `dma_addr` until `dma_ack`. The data on `dma_data` is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 level, 2 start code, 3 length code, 4 status |
| reg_wdata | input | 8 | Register write data |
| dma_req | output | 1 | Sample fetch request |
| dma_addr | output | 16 | Sample fetch address |
| dma_ack | input | 1 | Fetch acknowledge; dma_data is valid in this cycle |
| dma_data | input | 8 | Fetched sample byte |
| level | output | 7 | Output level |
| active | output | 1 | Bytes remain to be fetched |
| irq_pull_low | output | 1 | Open-drain enable for the active-low interrupt line |

## Verification
Register effects on `level`, `active` and `irq_pull_low` appear one clock after the write edge. The bench samples them on the falling edge that follows each write task. A fetch request rises one cycle after the buffer empties and is dropped in the cycle after the acknowledge. The bench's responder works on falling edges, checks that a delayed request is still held, and pops each expected address from a queue at the moment it acknowledges. Level steps depend on the timer phase, so the period is measured as the distance between two consecutive level changes after a settling change. Clamp results are read only after enough periods have passed for the buffered bytes to drain.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  localparam int DATA_W   = 8;
  localparam int LEVEL_W  = 7;
  localparam int ADDR_W   = 16;
  localparam int RATE_W   = 4;
  localparam int PERIOD_W = 9;
  localparam int LEN_W    = 12;
  localparam int SEL_W    = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL   = 3'd0,
    SEL_LEVEL  = 3'd1,
    SEL_START  = 3'd2,
    SEL_LEN    = 3'd3,
    SEL_STATUS = 3'd4
  } reg_sel_e;

  // control byte: [7] irq enable, [6] loop, [3:0] rate index
  typedef struct packed {
    logic              irq_en;
    logic              loop_en;
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  localparam int CTRL_IRQ_BIT  = 7;
  localparam int CTRL_LOOP_BIT = 6;
  localparam int STATUS_GO_BIT = 4;

  function automatic logic [PERIOD_W-1:0] rate_period(input logic [RATE_W-1:0] idx);
    logic [PERIOD_W-1:0] p;
    case (idx)
      4'd0:  p = 9'd428;
      4'd1:  p = 9'd380;
      4'd2:  p = 9'd340;
      4'd3:  p = 9'd320;
      4'd4:  p = 9'd286;
      4'd5:  p = 9'd254;
      4'd6:  p = 9'd226;
      4'd7:  p = 9'd214;
      4'd8:  p = 9'd190;
      4'd9:  p = 9'd160;
      4'd10: p = 9'd142;
      4'd11: p = 9'd128;
      4'd12: p = 9'd106;
      4'd13: p = 9'd84;
      4'd14: p = 9'd72;
      default: p = 9'd54;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/dsd_regs.sv
module dsd_regs
  import dsd_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int LVW = LEVEL_W,
  parameter int SW  = SEL_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [SW-1:0]  sel,
  input  logic [DW-1:0]  wdata,
  output ctrl_t          ctrl,
  output logic [DW-1:0]  start_code,
  output logic [DW-1:0]  len_code,
  output logic           level_wr,
  output logic [LVW-1:0] level_val,
  output logic           status_wr,
  output logic           status_go,
  output logic           irq_off
);
  logic hit_ctrl, hit_start, hit_len;

  assign hit_ctrl  = we && (sel == SEL_CTRL);
  assign hit_start = we && (sel == SEL_START);
  assign hit_len   = we && (sel == SEL_LEN);
  assign level_wr  = we && (sel == SEL_LEVEL);
  assign status_wr = we && (sel == SEL_STATUS);
  assign level_val = wdata[LVW-1:0];
  assign status_go = wdata[STATUS_GO_BIT];
  assign irq_off   = hit_ctrl && !wdata[CTRL_IRQ_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl       <= '0;
      start_code <= '0;
      len_code   <= '0;
    end else begin
      if (hit_ctrl) begin
        ctrl.irq_en  <= wdata[CTRL_IRQ_BIT];
        ctrl.loop_en <= wdata[CTRL_LOOP_BIT];
        ctrl.rate    <= wdata[RATE_W-1:0];
      end
      if (hit_start) start_code <= wdata;
      if (hit_len)   len_code   <= wdata;
    end
  end
endmodule

// File: rtl/dsd_timer.sv
module dsd_timer
  import dsd_pkg::*;
#(
  parameter int PW = PERIOD_W,
  parameter int RW = RATE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] rate,
  output logic          tick
);
  logic [PW-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= rate_period(rate) - PW'(1);
    else           cnt <= cnt - PW'(1);
  end
endmodule

// File: rtl/dsd_reader.sv
module dsd_reader
  import dsd_pkg::*;
#(
  parameter int          AW     = ADDR_W,
  parameter int          DW     = DATA_W,
  parameter int          LW     = LEN_W,
  parameter logic [15:0] BASE   = 16'hC000,
  parameter logic [15:0] WRAP   = 16'h8000,
  parameter int          BLK_SH = 6,
  parameter int          LEN_SH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loop_en,
  input  logic          irq_en,
  input  logic [DW-1:0] start_code,
  input  logic [DW-1:0] len_code,
  input  logic          status_wr,
  input  logic          status_go,
  input  logic          irq_off,
  input  logic          buf_take,
  input  logic          dma_ack,
  input  logic [DW-1:0] dma_data,
  output logic          dma_req,
  output logic [AW-1:0] dma_addr,
  output logic          buf_full,
  output logic [DW-1:0] buf_data,
  output logic          active,
  output logic          irq_flag
);
  localparam logic [AW-1:0] ADDR_MAX = {AW{1'b1}};

  logic [AW-1:0] ptr, n_ptr, n_req_addr, start_addr;
  logic [LW-1:0] rem, n_rem, len_bytes;
  logic          n_req, n_full, n_irq;
  logic [DW-1:0] n_data;

  assign start_addr = AW'(BASE) + (AW'(start_code) << BLK_SH);
  assign len_bytes  = (LW'(len_code) << LEN_SH) + LW'(1);
  assign active     = (rem != '0);

  always_comb begin
    n_ptr      = ptr;
    n_rem      = rem;
    n_req      = dma_req;
    n_req_addr = dma_addr;
    n_full     = buf_full;
    n_data     = buf_data;
    n_irq      = irq_flag;
    if (buf_take) n_full = 1'b0;
    if (dma_req && dma_ack) begin
      n_req  = 1'b0;
      n_full = 1'b1;
      n_data = dma_data;
      if (rem != '0) begin
        n_ptr = (ptr == ADDR_MAX) ? AW'(WRAP) : ptr + AW'(1);
        n_rem = rem - LW'(1);
        if (rem == LW'(1)) begin
          if (loop_en) begin
            n_ptr = start_addr;
            n_rem = len_bytes;
          end else if (irq_en) begin
            n_irq = 1'b1;
          end
        end
      end
    end else if (!dma_req && !buf_full && rem != '0) begin
      n_req      = 1'b1;
      n_req_addr = ptr;
    end
    if (irq_off) n_irq = 1'b0;
    if (status_wr) begin
      n_irq = 1'b0;
      if (status_go) begin
        if (n_rem == '0) begin
          n_ptr = start_addr;
          n_rem = len_bytes;
        end
      end else begin
        n_rem = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= AW'(BASE);
      rem      <= '0;
      dma_req  <= 1'b0;
      dma_addr <= AW'(BASE);
      buf_full <= 1'b0;
      buf_data <= '0;
      irq_flag <= 1'b0;
    end else begin
      ptr      <= n_ptr;
      rem      <= n_rem;
      dma_req  <= n_req;
      dma_addr <= n_req_addr;
      buf_full <= n_full;
      buf_data <= n_data;
      irq_flag <= n_irq;
    end
  end
endmodule

// File: rtl/dsd_output.sv
module dsd_output
  import dsd_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int LVW = LEVEL_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           buf_full,
  input  logic [DW-1:0]  buf_data,
  input  logic           level_wr,
  input  logic [LVW-1:0] level_val,
  output logic           buf_take,
  output logic [LVW-1:0] level
);
  localparam int             BCW    = $clog2(DW + 1);
  localparam logic [LVW-1:0] LV_TOP = {LVW{1'b1}};
  localparam logic [LVW-1:0] STEP   = LVW'(2);

  logic [DW-1:0]  shift;
  logic [BCW-1:0] bits_left;
  logic           silent;
  logic [LVW-1:0] stepped;
  logic           byte_end;

  assign byte_end = (bits_left == BCW'(1));
  assign buf_take = tick && byte_end && buf_full;

  always_comb begin
    stepped = level;
    if (shift[0]) begin
      if (level <= LV_TOP - STEP) stepped = level + STEP;
    end else begin
      if (level >= STEP) stepped = level - STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift     <= '0;
      bits_left <= BCW'(1);
      silent    <= 1'b1;
      level     <= '0;
    end else begin
      if (tick) begin
        if (!silent) begin
          level <= stepped;
          shift <= shift >> 1;
        end
        if (byte_end) begin
          bits_left <= BCW'(DW);
          if (buf_full) begin
            shift  <= buf_data;
            silent <= 1'b0;
          end else begin
            silent <= 1'b1;
          end
        end else begin
          bits_left <= bits_left - BCW'(1);
        end
      end
      if (level_wr) level <= level_val;
    end
  end
endmodule

// File: rtl/dsd_channel.sv
module dsd_channel
  import dsd_pkg::*;
#(
  parameter int          AW     = ADDR_W,
  parameter int          DW     = DATA_W,
  parameter int          LVW    = LEVEL_W,
  parameter int          SW     = SEL_W,
  parameter int          LW     = LEN_W,
  parameter logic [15:0] BASE   = 16'hC000,
  parameter logic [15:0] WRAP   = 16'h8000,
  parameter int          BLK_SH = 6,
  parameter int          LEN_SH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [SW-1:0]  reg_sel,
  input  logic [DW-1:0]  reg_wdata,
  output logic           dma_req,
  output logic [AW-1:0]  dma_addr,
  input  logic           dma_ack,
  input  logic [DW-1:0]  dma_data,
  output logic [LVW-1:0] level,
  output logic           active,
  output logic           irq_pull_low
);
  ctrl_t          ctrl;
  logic [DW-1:0]  start_code, len_code, buf_data;
  logic           level_wr, status_wr, status_go, irq_off;
  logic [LVW-1:0] level_val;
  logic           tick, buf_take, buf_full;

  dsd_regs #(.DW(DW), .LVW(LVW), .SW(SW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .ctrl(ctrl), .start_code(start_code), .len_code(len_code),
    .level_wr(level_wr), .level_val(level_val),
    .status_wr(status_wr), .status_go(status_go), .irq_off(irq_off)
  );

  dsd_timer #(.PW(PERIOD_W), .RW(RATE_W)) u_timer (
    .clk(clk), .rst(rst), .rate(ctrl.rate), .tick(tick)
  );

  dsd_reader #(
    .AW(AW), .DW(DW), .LW(LW), .BASE(BASE), .WRAP(WRAP),
    .BLK_SH(BLK_SH), .LEN_SH(LEN_SH)
  ) u_reader (
    .clk(clk), .rst(rst), .loop_en(ctrl.loop_en), .irq_en(ctrl.irq_en),
    .start_code(start_code), .len_code(len_code),
    .status_wr(status_wr), .status_go(status_go), .irq_off(irq_off),
    .buf_take(buf_take), .dma_ack(dma_ack), .dma_data(dma_data),
    .dma_req(dma_req), .dma_addr(dma_addr), .buf_full(buf_full),
    .buf_data(buf_data), .active(active), .irq_flag(irq_pull_low)
  );

  dsd_output #(.DW(DW), .LVW(LVW)) u_out (
    .clk(clk), .rst(rst), .tick(tick), .buf_full(buf_full),
    .buf_data(buf_data), .level_wr(level_wr), .level_val(level_val),
    .buf_take(buf_take), .level(level)
  );
endmodule

// File: rtl/dsd_channel_chk.sv
module dsd_channel_chk
  import dsd_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int DW  = DATA_W,
  parameter int LVW = LEVEL_W,
  parameter int SW  = SEL_W
) (
  input logic           clk,
  input logic           rst,
  input logic           reg_we,
  input logic [SW-1:0]  reg_sel,
  input logic [DW-1:0]  reg_wdata,
  input logic           dma_req,
  input logic [AW-1:0]  dma_addr,
  input logic           dma_ack,
  input logic [LVW-1:0] level,
  input logic           irq_pull_low
);
  logic status_hit, irq_off_hit, level_hit;
  assign status_hit  = reg_we && (reg_sel == SEL_STATUS);
  assign irq_off_hit = reg_we && (reg_sel == SEL_CTRL) && !reg_wdata[CTRL_IRQ_BIT];
  assign level_hit   = reg_we && (reg_sel == SEL_LEVEL);

  // R12: request held and address stable until acknowledged
  a_r12_req_held: assert property (@(posedge clk) disable iff (rst)
    dma_req && !dma_ack |=> dma_req);
  a_r12_addr_stable: assert property (@(posedge clk) disable iff (rst)
    dma_req && !dma_ack |=> $stable(dma_addr));

  // R3: fetch addresses stay in the upper half of memory
  a_r3_addr_upper: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> dma_addr[AW-1]);

  // R5: without a direct load the level moves by 0 or 2
  a_r5_step_size: assert property (@(posedge clk) disable iff (rst)
    !level_hit |=> (level == $past(level)) ||
                   ({1'b0, level} == {1'b0, $past(level)} + 8'd2) ||
                   ({1'b0, $past(level)} == {1'b0, level} + 8'd2));

  // R7: a pending interrupt is held until acknowledged
  a_r7_irq_holds: assert property (@(posedge clk) disable iff (rst)
    irq_pull_low && !status_hit && !irq_off_hit |=> irq_pull_low);

  // R8: status write acknowledges
  a_r8_status_ack: assert property (@(posedge clk) disable iff (rst)
    status_hit |=> !irq_pull_low);

  // R10: disabling the interrupt clears it
  a_r10_disable_clears: assert property (@(posedge clk) disable iff (rst)
    irq_off_hit |=> !irq_pull_low);
endmodule

bind dsd_channel dsd_channel_chk #(.AW(AW), .DW(DW), .LVW(LVW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .dma_req(dma_req), .dma_addr(dma_addr), .dma_ack(dma_ack),
  .level(level), .irq_pull_low(irq_pull_low)
);

// File: tb/tb_dsd_channel.sv
module tb_dsd_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        dma_req;
  logic [15:0] dma_addr;
  logic        dma_ack = 1'b0;
  logic [7:0]  dma_data = '0;
  logic [6:0]  level;
  logic        active;
  logic        irq_pull_low;

  int checks = 0, failures = 0;
  int acks = 0;
  int ack_delay = 0;
  bit strict = 1'b1;
  logic [15:0] loop_addr = 16'hC040;
  logic [7:0]  pattern = 8'hFF;
  logic [15:0] exp_q[$];
  longint cyc = 0;

  always #2.5 clk = ~clk;

  dsd_channel dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .dma_req(dma_req), .dma_addr(dma_addr), .dma_ack(dma_ack), .dma_data(dma_data),
    .level(level), .active(active), .irq_pull_low(irq_pull_low)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // DMA responder and scoreboard monitor
  initial begin
    int waited = 0;
    forever begin
      @(negedge clk);
      if (dma_ack) begin
        dma_ack = 1'b0;
      end else if (dma_req) begin
        if (waited < ack_delay) begin
          waited++;
        end else begin
          if (waited > 0) check(dma_req == 1'b1, "R12 request held", dma_req, 1);
          waited = 0;
          if (exp_q.size() > 0) begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check(dma_addr == e, "R3 fetch address", dma_addr, e);
          end else if (strict) begin
            check(1'b0, "R4 unexpected fetch", dma_addr, 0);
          end else begin
            check(dma_addr == loop_addr, "R11 loop address", dma_addr, loop_addr);
          end
          dma_data = pattern;
          dma_ack = 1'b1;
          acks++;
        end
      end
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    int n = 0;
    while (active && n < limit) begin @(negedge clk); n++; end
    check(!active, "R4 playback ends", active, 0);
  endtask

  task automatic wait_acks(input int target, input int limit);
    int n = 0;
    while (acks < target && n < limit) begin @(negedge clk); n++; end
    check(acks >= target, "R11 fetches continue", acks, target);
  endtask

  task automatic wait_change(output longint t);
    logic [6:0] prev;
    int n = 0;
    prev = level;
    while (level == prev && n < 2000) begin @(negedge clk); n++; end
    t = cyc;
  endtask

  task automatic run_all();
    int base;
    longint t1, t2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(level == 0, "R1 level", level, 0);
    check(!irq_pull_low, "R1 irq", irq_pull_low, 0);
    check(!active, "R1 active", active, 0);
    check(!dma_req, "R1 dma_req", dma_req, 0);
    // R6 direct load
    wr(3'd1, 8'h35);
    check(level == 7'h35, "R6 level load", level, 7'h35);
    wr(3'd1, 8'hC2);
    check(level == 7'h42, "R6 bit7 ignored", level, 7'h42);
    // single byte with irq
    wr(3'd0, 8'h8F); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    exp_q.push_back(16'hC000);
    base = acks;
    wr(3'd4, 8'h10);
    check(active, "R9 restart when idle", active, 1);
    wait_idle(2000);
    repeat (4) @(negedge clk);
    check(irq_pull_low, "R7 irq at end", irq_pull_low, 1);
    check(acks - base == 1, "R4 one byte for L=0", acks - base, 1);
    repeat (500) @(negedge clk);
    check(irq_pull_low, "R7 irq held", irq_pull_low, 1);
    wr(3'd4, 8'h00);
    check(!irq_pull_low, "R8 status ack", irq_pull_low, 0);
    // R10
    exp_q.push_back(16'hC000);
    wr(3'd4, 8'h10);
    wait_idle(2000);
    repeat (4) @(negedge clk);
    check(irq_pull_low, "R10 irq pending", irq_pull_low, 1);
    wr(3'd0, 8'h0F);
    check(!irq_pull_low, "R10 disable clears", irq_pull_low, 0);
    // R7 without enable
    exp_q.push_back(16'hC000);
    wr(3'd4, 8'h10);
    wait_idle(2000);
    repeat (20) @(negedge clk);
    check(!irq_pull_low, "R7 no irq when disabled", irq_pull_low, 0);
    // R4 length 17
    wr(3'd3, 8'h01);
    for (int i = 0; i < 17; i++) exp_q.push_back(16'hC000 + 16'(i));
    base = acks;
    wr(3'd4, 8'h10);
    wait_idle(20000);
    repeat (4) @(negedge clk);
    check(acks - base == 17, "R4 L=1 gives 17 bytes", acks - base, 17);
    // R3 wrap with delayed acknowledge (R12)
    ack_delay = 3;
    wr(3'd2, 8'hFF); wr(3'd3, 8'h04);
    for (int i = 0; i < 64; i++) exp_q.push_back(16'hFFC0 + 16'(i));
    exp_q.push_back(16'h8000);
    base = acks;
    wr(3'd4, 8'h10);
    wait_idle(60000);
    repeat (8) @(negedge clk);
    check(acks - base == 65, "R3 wrap byte count", acks - base, 65);
    check(exp_q.size() == 0, "R3 all addresses seen", exp_q.size(), 0);
    ack_delay = 0;
    // R11 loop
    strict = 1'b0;
    wr(3'd0, 8'hCF); wr(3'd2, 8'h01); wr(3'd3, 8'h00);
    base = acks;
    wr(3'd4, 8'h10);
    wait_acks(base + 6, 10000);
    check(!irq_pull_low, "R11 no irq in loop", irq_pull_low, 0);
    check(active, "R11 still active", active, 1);
    // R2 periods
    wr(3'd1, 8'h00); wr(3'd0, 8'hC0);
    wait_change(t1); wait_change(t1); wait_change(t2);
    check(t2 - t1 == 428, "R2 period index 0", t2 - t1, 428);
    wr(3'd0, 8'hCF); wr(3'd1, 8'h00);
    wait_change(t1); wait_change(t1); wait_change(t2);
    check(t2 - t1 == 54, "R2 period index 15", t2 - t1, 54);
    // R5 clamps
    wr(3'd1, 8'd124);
    repeat (10 * 54) @(negedge clk);
    check(level == 126, "R5 upper clamp", level, 126);
    pattern = 8'h00;
    repeat (20 * 54) @(negedge clk);
    wr(3'd1, 8'd100);
    repeat (3 * 54) @(negedge clk);
    check(level < 100 && ((100 - level) % 2 == 0), "R5 zero bits step down", level, 94);
    wr(3'd1, 8'd3);
    check(level == 3, "R6 load while playing", level, 3);
    repeat (10 * 54) @(negedge clk);
    check(level == 1, "R5 lower clamp", level, 1);
    // R9 stop
    wr(3'd4, 8'h00);
    check(!active, "R9 stop clears remaining", active, 0);
    repeat (20) @(negedge clk);
    base = acks;
    strict = 1'b1;
    repeat (2000) @(negedge clk);
    check(acks == base, "R9 no fetch after stop", acks - base, 0);
    check(!irq_pull_low, "R9 stop raises no irq", irq_pull_low, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule